// File: doc/BRIEF.md
# Three-Channel Compare Tick Timer

This block holds three independent 32-bit up-counters that advance on a shared one-microsecond strobe. Each counter is paired with a 32-bit compare value. When an advancing counter lands on its compare value, the channel latches a sticky pending flag. A per-channel wrap mode returns the counter to zero on that match instead of letting it run on, which gives a periodic interrupt whose period in microseconds equals the compare value.

Software reaches every 32-bit quantity through a 16-bit register port, one half at a time. Writes to the upper half are held in a staging register and take effect together with the lower half. A read of the counter's upper half captures its lower half, so two reads return one coherent value. The pending flags of all channels and an external abort level are combined into a single active-low interrupt line. A status word reports which source is active.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every channel's control, compare and counter reads 0, the status word reads 0 and `irq_n` is 1.
- R2: Address bits [4:3] select channel 0..2 (value 3 selects the status word) and bits [2:0] select the register within a channel: 0 control, 1 compare upper, 2 compare lower, 3 counter upper, 4 counter lower. A write to an upper half only stages it. A write to the matching lower half loads the whole 32-bit value (staged upper, written lower), and the readable compare does not change before that lower write.
- R3: Control bit 0 is the run enable. While it is 1, the counter rises by one in each clock cycle in which `tick_1us` is 1, with carry across the 16-bit halves. While it is 0, the counter holds.
- R4: When an advancing tick makes a running counter equal its compare value, that channel's pending flag is set.
- R5: With control bit 1 (wrap) set, the advancing tick that would reach the compare value loads zero instead, so a compare value of N gives one match every N ticks.
- R6: With wrap clear, the counter moves on past the compare value after a match.
- R7: Reading the counter upper half captures the lower half at that moment. A later read of the counter lower half returns the captured value even if the counter has moved since.
- R8: The status word holds the pending flags of channels 0, 1 and 2 in bits 0, 1 and 2, and the abort level in bit 3. Writing 1 to a pending bit clears it, and writing 0 leaves it. A match in the same cycle as a clear leaves the flag set.
- R9: `irq_n` is 0 exactly while any pending flag is set or `abort_in` is 1.
- R10: A channel's counter, compare and flag are unaffected by ticks, matches and writes that belong to another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1us | input | 1 | One-cycle strobe at 1 MHz, synchronous to clk |
| abort_in | input | 1 | Active-high abort request level, shares the interrupt line |
| reg_addr | input | 5 | Register address: group in [4:3], register in [2:0] |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_rd | input | 1 | Read strobe, used for the counter capture |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the current address |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The bench goes after a counter that crosses the 16-bit boundary. A design with a broken carry would show a wrong upper half there. It checks that an upper-half write alone leaves the compare as it was; a design without staging would show a torn compare. It checks that the lower half read after a counter move still returns the captured value; a design without capture would return the live value. It drives a match in the same cycle as a write-one clear, where a design that gave the clear priority would lose an interrupt. It also checks that a wrapping channel fires on exactly every Nth tick, where an off-by-one match would stretch the period to N+1.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [2:0] {
    OFF_CTRL   = 3'd0,
    OFF_CMP_HI = 3'd1,
    OFF_CMP_LO = 3'd2,
    OFF_CNT_HI = 3'd3,
    OFF_CNT_LO = 3'd4
  } tt_off_e;

  typedef struct packed {
    logic wrap;
    logic run;
  } tt_ctrl_t;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tt_pkg::*;
#(
  parameter int CW = 32,
  localparam int HW = CW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  tt_off_e       off,
  input  logic [HW-1:0] wdata,
  output logic [HW-1:0] rdata,
  output logic          match
);
  tt_ctrl_t      ctrl_q, ctrl_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] cmp_stage_q, cmp_stage_d;
  logic [HW-1:0] cnt_stage_q, cnt_stage_d;
  logic [HW-1:0] snap_q, snap_d;

  logic [CW-1:0] cnt_inc;
  logic          hit, adv, cnt_load;

  assign cnt_inc  = cnt_q + 1'b1;
  assign hit      = (cnt_inc == cmp_q);
  assign adv      = ctrl_q.run && tick;
  assign cnt_load = wr_en && (off == OFF_CNT_LO);
  assign match    = adv && hit && !cnt_load;

  // next-state logic
  always_comb begin
    ctrl_d      = ctrl_q;
    cmp_d       = cmp_q;
    cnt_d       = cnt_q;
    cmp_stage_d = cmp_stage_q;
    cnt_stage_d = cnt_stage_q;
    snap_d      = snap_q;

    if (wr_en) begin
      case (off)
        OFF_CTRL:   ctrl_d      = tt_ctrl_t'(wdata[1:0]);
        OFF_CMP_HI: cmp_stage_d = wdata;
        OFF_CMP_LO: cmp_d       = {cmp_stage_q, wdata};
        OFF_CNT_HI: cnt_stage_d = wdata;
        OFF_CNT_LO: cnt_d       = {cnt_stage_q, wdata};
        default:    ;
      endcase
    end

    if (adv && !cnt_load) begin
      cnt_d = (hit && ctrl_q.wrap) ? '0 : cnt_inc;
    end

    if (rd_en && (off == OFF_CNT_HI)) begin
      snap_d = cnt_q[HW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_CTRL:   rdata[1:0] = ctrl_q;
      OFF_CMP_HI: rdata = cmp_q[CW-1:HW];
      OFF_CMP_LO: rdata = cmp_q[HW-1:0];
      OFF_CNT_HI: rdata = cnt_q[CW-1:HW];
      OFF_CNT_LO: rdata = snap_q;
      default:    rdata = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      cmp_q       <= '0;
      cnt_q       <= '0;
      cmp_stage_q <= '0;
      cnt_stage_q <= '0;
      snap_q      <= '0;
    end else begin
      ctrl_q      <= ctrl_d;
      cmp_q       <= cmp_d;
      cnt_q       <= cnt_d;
      cmp_stage_q <= cmp_stage_d;
      cnt_stage_q <= cnt_stage_d;
      snap_q      <= snap_d;
    end
  end

  // R3: a stopped counter holds unless software loads it
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cnt_load) |=> $stable(cnt_q));

  // R3: a running, non-wrapping tick steps by exactly one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_load && !(hit && ctrl_q.wrap)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: wrap mode returns to zero on the matching tick
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_load && hit && ctrl_q.wrap) |=> (cnt_q == '0));

  // R2: the compare only changes on a lower-half write
  a_r2_no_torn_compare: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && off == OFF_CMP_LO) |=> $stable(cmp_q));

  // R7: an upper counter read captures the lower half of that cycle
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == OFF_CNT_HI) |=> (snap_q == $past(cnt_q[HW-1:0])));
endmodule

// File: rtl/tt_irq_ctrl.sv
module tt_irq_ctrl #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] match,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  input  logic           abort_in,
  output logic [NCH-1:0] pend,
  output logic           irq_n
);
  logic [NCH-1:0] pend_q, pend_d, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    pend_d  = (pend_q & ~clr_eff) | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend  = pend_q;
  assign irq_n = !((|pend_q) || abort_in);

  // R4, R8: every match leaves its flag set, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |=> ((pend_q & $past(match)) == $past(match)));

  // R8: without a clear write a set flag stays set
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tt_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 32,
  localparam int HW = CW / 2,
  localparam int GW = $clog2(NCH + 1),
  localparam int AW = GW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1us,
  input  logic          abort_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [HW-1:0] reg_wdata,
  output logic [HW-1:0] reg_rdata,
  output logic          irq_n
);
  localparam logic [GW-1:0] STAT_GRP = GW'(NCH);

  logic           rst_sync_n;
  logic [GW-1:0]  grp;
  tt_off_e        off;
  logic [NCH-1:0] ch_match;
  logic [NCH-1:0] pend;
  logic [HW-1:0]  ch_rdata [NCH];
  logic           stat_sel;

  assign grp      = reg_addr[AW-1:3];
  assign off      = tt_off_e'(reg_addr[2:0]);
  assign stat_sel = (grp == STAT_GRP) && (off == OFF_CTRL);

  tt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = (grp == GW'(i));
    tt_channel #(.CW(CW)) u_ch (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tick  (tick_1us),
      .wr_en (reg_wr && sel),
      .rd_en (reg_rd && sel),
      .off   (off),
      .wdata (reg_wdata),
      .rdata (ch_rdata[i]),
      .match (ch_match[i])
    );
  end

  tt_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .match    (ch_match),
    .clr_we   (reg_wr && stat_sel),
    .clr_mask (reg_wdata[NCH-1:0]),
    .abort_in (abort_in),
    .pend     (pend),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (stat_sel)                reg_rdata[NCH:0] = {abort_in, pend};
    else if (grp < STAT_GRP)     reg_rdata = ch_rdata[grp];
  end

  // R9: the line is low whenever a flag is held
  a_r9_line_follows_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|pend) |-> !irq_n);
endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        abort_in = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  tick_timer_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1us  (tick_1us),
    .abort_in  (abort_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n)
  );

  localparam logic [2:0] OP_WR = 3'd0;
  localparam logic [2:0] OP_RD = 3'd1;
  localparam logic [2:0] OP_TK = 3'd2;
  localparam logic [2:0] OP_IQ = 3'd3;
  localparam logic [2:0] OP_AB = 3'd4;
  localparam int NV = 64;

  // entry: {requirement, op, address, data or expected value}
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, OP_RD, 5'd0,  16'h0000},  // R1 control
    {4'd1, OP_RD, 5'd3,  16'h0000},  // R1 counter upper
    {4'd1, OP_RD, 5'd24, 16'h0000},  // R1 status
    {4'd9, OP_IQ, 5'd0,  16'h0001},  // R9 idle line high
    {4'd2, OP_WR, 5'd1,  16'h0001},  // R2 stage compare upper
    {4'd2, OP_RD, 5'd1,  16'h0000},  // R2 not yet visible
    {4'd2, OP_WR, 5'd2,  16'h0002},  // R2 commit 0x00010002
    {4'd2, OP_RD, 5'd1,  16'h0001},
    {4'd2, OP_RD, 5'd2,  16'h0002},
    {4'd3, OP_TK, 5'd0,  16'd5},     // R3 ticks while stopped
    {4'd3, OP_RD, 5'd3,  16'h0000},
    {4'd3, OP_RD, 5'd4,  16'h0000},
    {4'd2, OP_WR, 5'd3,  16'h0000},  // R2 counter load 0x0000FFFE
    {4'd2, OP_WR, 5'd4,  16'hFFFE},
    {4'd3, OP_WR, 5'd0,  16'h0001},  // R3 run
    {4'd3, OP_TK, 5'd0,  16'd2},     // R3 carry to 0x00010000
    {4'd3, OP_RD, 5'd3,  16'h0001},
    {4'd3, OP_RD, 5'd4,  16'h0000},
    {4'd4, OP_RD, 5'd24, 16'h0000},  // R4 no match yet
    {4'd4, OP_TK, 5'd0,  16'd2},     // R4 reaches 0x00010002
    {4'd4, OP_RD, 5'd24, 16'h0001},
    {4'd9, OP_IQ, 5'd0,  16'h0000},  // R9 line low
    {4'd6, OP_TK, 5'd0,  16'd1},     // R6 runs past compare
    {4'd6, OP_RD, 5'd3,  16'h0001},
    {4'd6, OP_RD, 5'd4,  16'h0003},
    {4'd8, OP_WR, 5'd24, 16'h0000},  // R8 zero write leaves flag
    {4'd8, OP_RD, 5'd24, 16'h0001},
    {4'd8, OP_WR, 5'd24, 16'h0001},  // R8 write-one clear
    {4'd8, OP_RD, 5'd24, 16'h0000},
    {4'd9, OP_IQ, 5'd0,  16'h0001},
    {4'd5, OP_WR, 5'd9,  16'h0000},  // R5 channel 1 compare 3, wrap
    {4'd5, OP_WR, 5'd10, 16'h0003},
    {4'd5, OP_WR, 5'd8,  16'h0003},
    {4'd5, OP_TK, 5'd0,  16'd2},
    {4'd5, OP_RD, 5'd24, 16'h0000},
    {4'd5, OP_TK, 5'd0,  16'd1},
    {4'd5, OP_RD, 5'd24, 16'h0002},
    {4'd5, OP_RD, 5'd11, 16'h0000},  // R5 back at zero
    {4'd5, OP_RD, 5'd12, 16'h0000},
    {4'd8, OP_WR, 5'd24, 16'h0002},
    {4'd5, OP_TK, 5'd0,  16'd2},     // R5 second period
    {4'd5, OP_RD, 5'd24, 16'h0000},
    {4'd5, OP_TK, 5'd0,  16'd1},
    {4'd5, OP_RD, 5'd24, 16'h0002},
    {4'd7, OP_RD, 5'd11, 16'h0000},  // R7 capture low = 0
    {4'd7, OP_TK, 5'd0,  16'd2},
    {4'd7, OP_RD, 5'd12, 16'h0000},  // R7 captured, not live
    {4'd7, OP_RD, 5'd11, 16'h0000},
    {4'd7, OP_RD, 5'd12, 16'h0002},
    {4'd9, OP_AB, 5'd0,  16'h0001},  // R9 abort
    {4'd9, OP_IQ, 5'd0,  16'h0000},
    {4'd8, OP_RD, 5'd24, 16'h000A},  // R8 abort bit 3 + flag 1
    {4'd8, OP_WR, 5'd24, 16'h000A},
    {4'd8, OP_RD, 5'd24, 16'h0008},
    {4'd9, OP_IQ, 5'd0,  16'h0000},
    {4'd9, OP_AB, 5'd0,  16'h0000},
    {4'd9, OP_IQ, 5'd0,  16'h0001},
    {4'd10, OP_RD, 5'd19, 16'h0000}, // R10 channel 2 untouched
    {4'd10, OP_RD, 5'd20, 16'h0000},
    {4'd10, OP_RD, 5'd3,  16'h0001}, // R10 channel 0 at 0x0001000B
    {4'd10, OP_RD, 5'd4,  16'h000B},
    {4'd3, OP_WR, 5'd0,  16'h0000},
    {4'd3, OP_WR, 5'd8,  16'h0000},
    {4'd8, OP_WR, 5'd24, 16'h0007}
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #5;
    check(req, $sformatf("read addr %0d", a), reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk);
    tick_1us = 1'b1;
    repeat (n) @(negedge clk);
    tick_1us = 1'b0;
  endtask

  task automatic chk_irq(input int req, input logic exp);
    @(negedge clk);
    #5;
    check(req, "irq_n", {15'd0, irq_n}, {15'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [4:0]  ad;
      logic [15:0] dv;
      {rq, op, ad, dv} = VEC[k];
      case (op)
        OP_WR: do_wr(ad, dv);
        OP_RD: do_rd(int'(rq), ad, dv);
        OP_TK: do_ticks(int'(dv));
        OP_IQ: chk_irq(int'(rq), dv[0]);
        default: begin @(negedge clk); abort_in = dv[0]; end
      endcase
    end

    // R8: everything cleared after the table
    do_rd(8, 5'd24, 16'h0000);

    // R8: match and write-one clear in the same cycle, the flag survives
    do_wr(5'd17, 16'h0000);
    do_wr(5'd18, 16'h0002);
    do_wr(5'd16, 16'h0003);
    do_ticks(1);
    @(negedge clk);
    tick_1us = 1'b1; reg_addr = 5'd24; reg_wdata = 16'h0004; reg_wr = 1'b1;
    @(negedge clk);
    tick_1us = 1'b0; reg_wr = 1'b0;
    do_rd(8, 5'd24, 16'h0004);
    do_rd(5, 5'd19, 16'h0000);
    chk_irq(9, 1'b0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check(1, "irq_n during reset", {15'd0, irq_n}, 16'h0001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_rd(1, 5'd16, 16'h0000);
    do_rd(1, 5'd18, 16'h0000);
    do_rd(1, 5'd24, 16'h0000);
    do_ticks(3);
    do_rd(1, 5'd19, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule